// File: doc/BRIEF.md
# Oversampled Symbol Timing Recovery

This block recovers symbol timing from a stream of hard-decided symbols sampled at 32 times the symbol rate. A 5-bit phase counter advances once per oversample tick and is meant to sit at zero when a symbol boundary arrives. When the decided code changes between two consecutive ticks, the block treats this as a boundary. It then moves the counter one step toward zero: one step back if the boundary came after zero, one step forward if it came before.

When the counter reaches the middle count of 16, the block emits a one-cycle receive strobe and latches the current symbol as the retimed output. The decided symbol is an opaque code of parameterised width. The same loop therefore serves binary and multi-level streams, and a change of any bit counts as a boundary. Between boundaries the counter free-runs, so timing carries across runs of repeated symbols.

Top module: `symbol_timing_recovery`

## Requirements
- R1: After reset `rx_strobe` is 0 and `rx_sym` is 0. The phase counter starts at 0, and the previously sampled code is taken as 0.
- R2: With no code change, the counter advances by one per tick and wraps after 31. The first strobe follows the 16th tick after reset, and later strobes follow every 32 ticks.
- R3: `rx_strobe` is high for exactly one clock, in the cycle after the tick that moves the counter from 15 to 16. In that cycle `rx_sym` equals the code that was present at that tick, and `rx_sym` keeps its value until the next strobe.
- R4: A code change seen at counter value p in 1..15 (late) holds the counter at p for that tick. The next strobe then follows 17-p ticks later, counting the changing tick as the first.
- R5: A code change seen at counter value p in 16..31 (early) advances the counter by 2 modulo 32. The next strobe then follows 1+((14-p) mod 32) ticks later, counting the changing tick as the first.
- R6: A code change seen at counter value 0 causes no correction, and the next strobe follows 16 ticks later.
- R7: A boundary is any difference between the codes of two consecutive ticks, including changes in which only some bits flip (for example 1 to 2 and 2 to 3 with 2-bit codes).
- R8: Clock cycles without a tick change neither the counter nor the remembered code. `sym_in` values present in such cycles have no effect on later timing, and no strobe is issued in those cycles.
- R9: For every symbol, a stream whose code changes at each symbol, running 3% slow (33 ticks per symbol) or 3% fast (31 ticks per symbol), yields exactly one strobe. Each strobe lands at least 8 ticks away from both symbol boundaries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Oversample enable, 32 per symbol |
| sym_in | input | SYM_W | Decided symbol code, sampled on ticks |
| rx_strobe | output | 1 | One-cycle recovered clock strobe at mid-symbol |
| rx_sym | output | SYM_W | Retimed symbol, valid with and held after the strobe |

## Verification
The assertions take for granted that `tick` is never high on two consecutive clocks around a strobe, and that reset is applied before the first tick. The bench honours both by separating every tick with at least one idle cycle. In those idle cycles it deliberately drives an inverted code, to show that only ticked samples are seen. The rate-error runs start from reset with the first boundary a whole symbol later, so the loop enters its steady state from a known phase.

// File: rtl/symbol_timing_recovery.sv
module symbol_timing_recovery #(
  parameter int SYM_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [SYM_W-1:0] sym_in,
  output logic             rx_strobe,
  output logic [SYM_W-1:0] rx_sym
);
  localparam int OSR = 32;
  localparam int PW  = $clog2(OSR);
  localparam logic [PW-1:0] MID = PW'(OSR / 2);
  localparam logic [PW-1:0] ONE = PW'(1);
  localparam logic [PW-1:0] TWO = PW'(2);

  logic [PW-1:0]    phase, phase_nx;
  logic [SYM_W-1:0] last_sym;
  logic             edge_seen, early;

  assign edge_seen = sym_in != last_sym;
  assign early     = phase[PW-1];

  always_comb begin
    if (!edge_seen)       phase_nx = phase + ONE;
    else if (phase == '0) phase_nx = ONE;
    else if (early)       phase_nx = phase + TWO;
    else                  phase_nx = phase;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= '0;
      last_sym  <= '0;
      rx_strobe <= 1'b0;
      rx_sym    <= '0;
    end else begin
      rx_strobe <= 1'b0;
      if (tick) begin
        phase    <= phase_nx;
        last_sym <= sym_in;
        if (phase_nx == MID && phase != MID) begin
          rx_strobe <= 1'b1;
          rx_sym    <= sym_in;
        end
      end
    end
  end

  AST_STROBE_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    rx_strobe |-> $past(tick)); // R3
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_strobe |=> !rx_strobe); // R3
  AST_STROBE_AT_MID: assert property (@(posedge clk) disable iff (!rst_n)
    rx_strobe |-> phase == MID); // R2
  AST_SYM_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_strobe |-> $stable(rx_sym)); // R3
  AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(phase) && $stable(last_sym) && !rx_strobe); // R8
  AST_ZERO_NO_CORR: assert property (@(posedge clk) disable iff (!rst_n)
    tick && edge_seen && phase == '0 |=> phase == ONE); // R6
endmodule

// File: tb/tb_symbol_timing_recovery.sv
`timescale 1ns/1ps
module tb_symbol_timing_recovery;
  logic clk = 0, rst_n = 0, tick = 0;
  logic [1:0] sym_in = 0;
  logic rx_strobe;
  logic [1:0] rx_sym;
  int checks = 0, fails = 0, cyc = 0;
  bit st;
  logic [1:0] got;

  always #2.5 clk = ~clk;

  symbol_timing_recovery #(.SYM_W(2)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .sym_in(sym_in),
    .rx_strobe(rx_strobe), .rx_sym(rx_sym));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; tick = 0; sym_in = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  task automatic one_tick(input logic [1:0] s, output bit strobe, output logic [1:0] val);
    @(negedge clk); tick = 1; sym_in = s;
    @(negedge clk); strobe = rx_strobe; val = rx_sym; tick = 0; sym_in = ~s;
    @(negedge clk);
    chk(rx_strobe == 0, "R8 idle strobe", rx_strobe, 0);
  endtask

  function automatic int exp_gap(input int p);
    int np;
    if (p == 0) np = 1;
    else if (p < 16) np = p;
    else np = (p + 2) % 32;
    return 1 + (((16 - np) % 32) + 32) % 32;
  endfunction

  task automatic edge_at(input int p, input logic [1:0] a, input logic [1:0] b, input string req);
    int n;
    do_reset();
    for (int t = 0; t < p + 32; t++) one_tick(a, st, got);
    n = 0;
    do begin
      one_tick(b, st, got); n++;
    end while (!st && n < 70);
    chk(n == exp_gap(p), req, n, exp_gap(p));
    chk(got == b, "R3 rx_sym value", got, b);
  endtask

  task automatic rate_run(input int P, input bit quad);
    int last, idx, pos;
    logic [1:0] s;
    do_reset();
    last = -1;
    for (int t = 0; t < 60 * P; t++) begin
      idx = t / P;
      s = quad ? 2'(idx % 4) : 2'(idx % 2);
      one_tick(s, st, got);
      if (st) begin
        pos = t % P;
        chk(idx == last + 1, "R9 one strobe per symbol", idx, last + 1);
        chk(pos >= 8 && pos <= P - 8, "R9 strobe mid-symbol", pos, P / 2);
        chk(got == s, "R3 rx_sym value", got, s);
        last = idx;
      end
    end
    chk(last >= 58, "R9 symbol count", last, 59);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<190000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    chk(rx_strobe == 0, "R1 reset strobe", rx_strobe, 0);
    chk(rx_sym == 0, "R1 reset rx_sym", rx_sym, 0);
    for (int t = 1; t <= 100; t++) begin
      one_tick(2'd0, st, got);
      chk(st == ((t % 32) == 16), "R2 free-run strobe", st, (t % 32) == 16);
    end
    for (int p = 0; p < 32; p++) begin
      if (p == 0) edge_at(p, 2'd0, 2'd2, "R6 edge at zero");
      else if (p < 16) edge_at(p, 2'd0, 2'(p % 3 + 1), "R4 late edge");
      else edge_at(p, 2'd0, 2'(p % 3 + 1), "R5 early edge");
    end
    edge_at(5, 2'd2, 2'd3, "R7 partial change 2->3");
    edge_at(20, 2'd1, 2'd2, "R7 change 1->2");
    edge_at(9, 2'd1, 2'd3, "R7 change 1->3");
    rate_run(31, 1'b1);
    rate_run(33, 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule